// File: doc/BRIEF.md
# Grouped Sixteen-Input Interrupt Controller

This block collects sixteen external interrupt request lines, latches each request into a sticky pending flag, and folds the pending requests that are not masked into four active-high request outputs. Each output serves a fixed, irregular group of inputs. Inputs 0 to 14 are active-low and level-sensitive. Input 15 carries a push-button non-maskable request and is captured on its falling edge only.

A host reaches two 16-bit registers over a plain synchronous bus with an address, a write strobe, write data and registered read data. The mask register holds one bit per input, and a 1 in a bit blocks that input. The pending-flag register is cleared by writing zeros. Each 0 in the written word clears the matching flag, and each 1 leaves its flag as it is. A handler reads the flags and the mask, services the unmasked pending inputs of the group that raised its output, and clears their flags once the source has released its line.

Top module: `grp_irq_ctrl`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the mask register reads 0xFFFF, the flag register reads 0x0000 and all four outputs are 0.
- R2: Every request line passes through two synchronising flops. A level request that goes low just after edge E sets its flag at edge E+3, and the output of its group follows at edge E+4.
- R3: The flag of each input 0 to 14 is set on every clock edge at which its synchronised line is low, and it stays set after the line returns high until the host clears it.
- R4: The flag of input 15 is set only when its synchronised line goes from high to low. A line held low after a cleared edge does not set it again.
- R5: A write to the flag register at byte address 0xC clears each flag whose data bit is 0 and keeps each flag whose data bit is 1.
- R6: If a flag clear and a set condition for the same bit happen in one cycle, the flag ends up set.
- R7: A write to the mask register at byte address 0x4 loads the write data. A mask bit of 1 stops its pending flag from reaching any output, and a bit of 0 lets it through. The mask does not stop flags from being captured.
- R8: Each output is a registered OR over its group of pending, unmasked flags: output 0 over inputs 3 and 5 (0x0028), output 1 over inputs 4 and 6 (0x0050), output 2 over inputs 10, 11 and 12 (0x1C00), and output 3 over inputs 1, 2, 7, 8, 9, 13 and 14 (0x6386). An output changes one edge after the flag or mask change that causes it.
- R9: Flags 0 and 15 belong to no group. When only they are pending, all outputs stay 0.
- R10: Read data is registered. It shows the register addressed at edge E from edge E onward and holds the value from before any write in that same cycle. Any address other than 0x4 and 0xC reads 0x0000, and writes to such addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_line_n | input | 16 | Asynchronous request lines, active low |
| bus_addr | input | 4 | Byte address of the register |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered |
| irq_out | output | 4 | Grouped request outputs, active high, registered |

## Verification
The embedded properties rely on the bus being free of X values after reset, on the request lines being sampled only through the synchroniser, and on reset being the only event that reloads the registers outside a bus write. The bench drives all inputs half a period away from the active edge, never leaves a bus field undefined, and asserts reset only at the start. The directed phase places each line change and clear write in a known cycle. A long random phase then mixes changing request lines with writes to the mapped addresses and to unmapped ones, and a behavioural model compares the outputs with the design on every cycle.

// File: rtl/gic_pkg.sv
// Package gic_pkg
// Shared constants for the grouped interrupt controller: default sizes,
// register offsets, group membership and the edge-input selection.
// Assumes a 16-input, 4-output configuration as the default build.
package gic_pkg;

    localparam int IRQ_NUM  = 16;
    localparam int OUT_NUM  = 4;
    localparam int ADDR_W   = 4;
    localparam int SYNC_LEN = 2;

    // byte offsets of the two registers
    localparam logic [ADDR_W-1:0] MASK_OFS_DEF = 4'h4;
    localparam logic [ADDR_W-1:0] FLAG_OFS_DEF = 4'hC;

    // membership of each output, output 0 in the lowest slice
    localparam logic [OUT_NUM*IRQ_NUM-1:0] GROUP_DEF =
        {16'h6386, 16'h1C00, 16'h0050, 16'h0028};

    // inputs captured on a falling edge rather than on level
    localparam logic [IRQ_NUM-1:0] EDGE_DEF = 16'h8000;

    // mask value loaded at reset: everything blocked
    localparam logic [IRQ_NUM-1:0] MASK_RST_DEF = 16'hFFFF;

    // read-data source selection
    typedef enum logic [1:0] {
        RD_NONE = 2'd0,
        RD_MASK = 2'd1,
        RD_FLAG = 2'd2
    } rd_sel_e;

endpackage

// File: rtl/gic_sync.sv
// Module gic_sync
// Multi-flop synchroniser for a vector of asynchronous lines.
// Assumes each bit is an independent slow signal; no bus coherency is
// implied across bits. Reset loads the idle level so that lines held
// active during reset are seen only after reset is released.
module gic_sync #(
    parameter int               WIDTH  = 16,
    parameter int               STAGES = 2,
    parameter logic [WIDTH-1:0] IDLE   = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    // shift the sampled lines through the synchroniser chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= IDLE;
            end
        end else begin
            stage_q[0] <= din;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/gic_flags.sv
// Module gic_flags
// Pending-flag register with per-input capture. Level inputs set their
// flag on every cycle the synchronised line is low; edge inputs set it
// on a high-to-low transition. A host write clears flags whose data bit
// is 0. A set condition in the same cycle overrides the clear.
// Assumes line_s is already synchronised to clk.
module gic_flags #(
    parameter int             NUM      = 16,
    parameter logic [NUM-1:0] EDGE_SEL = 16'h8000
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NUM-1:0] line_s,
    input  logic           clr_we,
    input  logic [NUM-1:0] clr_data,
    output logic [NUM-1:0] flag_o
);

    logic [NUM-1:0] flag_q;
    logic [NUM-1:0] set_w;
    logic [NUM-1:0] keep_w;

    genvar i;
    generate
        for (i = 0; i < NUM; i++) begin : g_cap
            if (EDGE_SEL[i]) begin : g_edge
                logic prev_q;

                // remember the last synchronised sample of the edge line
                always_ff @(posedge clk) begin
                    if (!rst_n) prev_q <= 1'b1;
                    else        prev_q <= line_s[i];
                end

                assign set_w[i] = prev_q & ~line_s[i];

                // R4: an edge flag rises only after a falling transition
                p_edge_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
                    $rose(flag_q[i]) |-> ($past(prev_q) && !$past(line_s[i])));
            end else begin : g_level
                assign set_w[i] = ~line_s[i];
            end
        end
    endgenerate

    // flags the host write leaves alone
    assign keep_w = clr_we ? (flag_q & clr_data) : flag_q;

    // capture new requests and apply host clears, set taking priority
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= keep_w | set_w;
    end

    assign flag_o = flag_q;

    // R6: a bit with a set condition is pending on the next edge
    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (set_w != '0) |=> ((flag_q & $past(set_w)) == $past(set_w)));

    // R5: a clear with no competing set leaves exactly the kept bits
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && (set_w == '0)) |=> (flag_q == ($past(flag_q) & $past(clr_data))));

endmodule

// File: rtl/gic_regs.sv
// Module gic_regs
// Host register file: decodes the byte address, holds the mask register,
// produces the clear strobe for the flag register and registers read
// data. Unmapped addresses read as zero and ignore writes.
// Assumes one access per cycle and no wait states.
module gic_regs #(
    parameter int                NUM      = 16,
    parameter int                ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] MASK_OFS = 4'h4,
    parameter logic [ADDR_W-1:0] FLAG_OFS = 4'hC,
    parameter logic [NUM-1:0]    MASK_RST = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [NUM-1:0]    wdata,
    input  logic [NUM-1:0]    flag_i,
    output logic [NUM-1:0]    mask_o,
    output logic              flag_we_o,
    output logic [NUM-1:0]    rdata_o
);

    import gic_pkg::*;

    rd_sel_e        sel_w;
    logic [NUM-1:0] mask_q;
    logic [NUM-1:0] rdata_q;
    logic           mask_we_w;

    // pick the register addressed this cycle
    always_comb begin
        if (addr == MASK_OFS)      sel_w = RD_MASK;
        else if (addr == FLAG_OFS) sel_w = RD_FLAG;
        else                       sel_w = RD_NONE;
    end

    assign mask_we_w = we && (sel_w == RD_MASK);
    assign flag_we_o = we && (sel_w == RD_FLAG);

    // hold the mask value written by the host
    always_ff @(posedge clk) begin
        if (!rst_n)         mask_q <= MASK_RST;
        else if (mask_we_w) mask_q <= wdata;
    end

    // register the selected value for the read port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            unique case (sel_w)
                RD_MASK: rdata_q <= mask_q;
                RD_FLAG: rdata_q <= flag_i;
                default: rdata_q <= '0;
            endcase
        end
    end

    assign mask_o  = mask_q;
    assign rdata_o = rdata_q;

    // R7: a mask write lands on the next edge
    p_mask_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we_w |=> (mask_q == $past(wdata)));

    // R10: unmapped addresses read zero
    p_unmapped_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((addr != MASK_OFS) && (addr != FLAG_OFS)) |=> (rdata_o == '0));

    // R10: writes to unmapped addresses do not touch the mask
    p_unmapped_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (addr != MASK_OFS)) |=> (mask_q == $past(mask_q)));

endmodule

// File: rtl/gic_group.sv
// Module gic_group
// Folds pending, unmasked flags into the grouped request outputs. Each
// output has a fixed membership vector; the result is registered.
// Assumes flag and mask come from registers in the same clock domain.
module gic_group #(
    parameter int                     NUM     = 16,
    parameter int                     OUTS    = 4,
    parameter logic [OUTS*NUM-1:0]    GRP_MAP = 64'h6386_1C00_0050_0028
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NUM-1:0]  flag_i,
    input  logic [NUM-1:0]  mask_i,
    output logic [OUTS-1:0] irq_o
);

    localparam logic [NUM-1:0] ANY_GRP = any_member(GRP_MAP);

    function automatic logic [NUM-1:0] any_member(input logic [OUTS*NUM-1:0] map);
        logic [NUM-1:0] acc;
        acc = '0;
        for (int k = 0; k < OUTS; k++) acc |= map[k*NUM +: NUM];
        return acc;
    endfunction

    logic [OUTS-1:0] hit_w;
    logic [OUTS-1:0] irq_q;

    genvar k;
    generate
        for (k = 0; k < OUTS; k++) begin : g_out
            localparam logic [NUM-1:0] MEMBERS = GRP_MAP[k*NUM +: NUM];

            assign hit_w[k] = |(flag_i & ~mask_i & MEMBERS);

            // R8: an output rises only when one of its members was live
            p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(irq_q[k]) |-> $past(|(flag_i & MEMBERS & ~mask_i)));

            // R7: a fully masked group keeps its output low
            p_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
                ((mask_i & MEMBERS) == MEMBERS) |=> !irq_q[k]);
        end
    endgenerate

    // register the grouped requests
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= '0;
        else        irq_q <= hit_w;
    end

    assign irq_o = irq_q;

    // R9: flags outside every group never drive an output
    p_no_group_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_i & ~mask_i & ANY_GRP) == '0) |=> (irq_q == '0));

endmodule

// File: rtl/grp_irq_ctrl.sv
// Module grp_irq_ctrl
// Top of the grouped interrupt controller: synchronises the active-low
// request lines, captures them into pending flags, applies the mask and
// drives the grouped outputs. Register access through a simple
// synchronous bus with registered read data.
// Assumes a single clock and a synchronous active-low reset.
module grp_irq_ctrl #(
    parameter int                              NUM_IRQ   = gic_pkg::IRQ_NUM,
    parameter int                              NUM_OUT   = gic_pkg::OUT_NUM,
    parameter int                              ADDR_W    = gic_pkg::ADDR_W,
    parameter int                              SYNC_LEN  = gic_pkg::SYNC_LEN,
    parameter logic [ADDR_W-1:0]               MASK_OFS  = gic_pkg::MASK_OFS_DEF,
    parameter logic [ADDR_W-1:0]               FLAG_OFS  = gic_pkg::FLAG_OFS_DEF,
    parameter logic [NUM_OUT*NUM_IRQ-1:0]      GROUP_MAP = gic_pkg::GROUP_DEF,
    parameter logic [NUM_IRQ-1:0]              EDGE_SEL  = gic_pkg::EDGE_DEF,
    parameter logic [NUM_IRQ-1:0]              MASK_RST  = gic_pkg::MASK_RST_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_line_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_we,
    input  logic [NUM_IRQ-1:0] bus_wdata,
    output logic [NUM_IRQ-1:0] bus_rdata,
    output logic [NUM_OUT-1:0] irq_out
);

    logic [NUM_IRQ-1:0] line_s;
    logic [NUM_IRQ-1:0] flag_w;
    logic [NUM_IRQ-1:0] mask_w;
    logic               flag_we_w;

    gic_sync #(
        .WIDTH  (NUM_IRQ),
        .STAGES (SYNC_LEN),
        .IDLE   ({NUM_IRQ{1'b1}})
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (irq_line_n),
        .dout  (line_s)
    );

    gic_flags #(
        .NUM      (NUM_IRQ),
        .EDGE_SEL (EDGE_SEL)
    ) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_s   (line_s),
        .clr_we   (flag_we_w),
        .clr_data (bus_wdata),
        .flag_o   (flag_w)
    );

    gic_regs #(
        .NUM      (NUM_IRQ),
        .ADDR_W   (ADDR_W),
        .MASK_OFS (MASK_OFS),
        .FLAG_OFS (FLAG_OFS),
        .MASK_RST (MASK_RST)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (bus_addr),
        .we        (bus_we),
        .wdata     (bus_wdata),
        .flag_i    (flag_w),
        .mask_o    (mask_w),
        .flag_we_o (flag_we_w),
        .rdata_o   (bus_rdata)
    );

    gic_group #(
        .NUM     (NUM_IRQ),
        .OUTS    (NUM_OUT),
        .GRP_MAP (GROUP_MAP)
    ) u_group (
        .clk    (clk),
        .rst_n  (rst_n),
        .flag_i (flag_w),
        .mask_i (mask_w),
        .irq_o  (irq_out)
    );

    // R3: a level line seen low is pending on the following edge
    p_level_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_s[1]) |=> flag_w[1]);

endmodule

// File: tb/test_grp_irq_ctrl.sv
module test_grp_irq_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 50000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] line_n = 16'hFFFF;
    logic [3:0]  baddr = 4'h0;
    logic        bwe = 1'b0;
    logic [15:0] bwd = 16'h0000;
    logic [15:0] rdata;
    logic [3:0]  irq;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit done   = 0;
    bit cmp_en = 0;

    grp_irq_ctrl i_grp_irq_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_line_n (line_n),
        .bus_addr   (baddr),
        .bus_we     (bwe),
        .bus_wdata  (bwd),
        .bus_rdata  (rdata),
        .irq_out    (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // ---------------- behavioural reference ----------------
    logic [15:0] m_mask, m_flag, m_rd;
    logic [3:0]  m_irq;
    logic [15:0] m_hist[$];
    logic [15:0] grp[4] = '{16'h0028, 16'h0050, 16'h1C00, 16'h6386};

    always @(posedge clk) begin
        logic [15:0] seen, older, setv, nf, nm, nr;
        logic [3:0]  ni;
        if (!rst_n) begin
            m_mask = 16'hFFFF; m_flag = 16'h0000; m_rd = 16'h0000; m_irq = 4'h0;
            m_hist = '{16'hFFFF, 16'hFFFF, 16'hFFFF};
        end else begin
            seen  = m_hist[1];
            older = m_hist[2];
            setv  = ~seen & 16'h7FFF;
            if (older[15] && !seen[15]) setv[15] = 1'b1;
            nf = ((bwe && baddr == 4'hC) ? (m_flag & bwd) : m_flag) | setv;
            nm = (bwe && baddr == 4'h4) ? bwd : m_mask;
            for (int k = 0; k < 4; k++) ni[k] = |(m_flag & ~m_mask & grp[k]);
            if (baddr == 4'h4)      nr = m_mask;
            else if (baddr == 4'hC) nr = m_flag;
            else                    nr = 16'h0000;
            m_flag = nf; m_mask = nm; m_irq = ni; m_rd = nr;
            m_hist.push_front(line_n);
            void'(m_hist.pop_back());
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // compare with the model every cycle, away from the active edge
    always @(negedge clk) begin
        if (cmp_en && !done) begin
            chk("R8 model irq", {12'h0, irq}, {12'h0, m_irq});
            chk("R10 model rdata", rdata, m_rd);
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: run still active after %0d cycles", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // ---------------- bus and stimulus tasks ----------------
    task automatic bus_wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk); baddr = a; bwe = 1'b1; bwd = d;
        @(negedge clk); bwe = 1'b0;
    endtask

    task automatic bus_rd(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk); baddr = a; bwe = 1'b0;
        @(negedge clk); d = rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_all();
        @(negedge clk); line_n = 16'hFFFF;
        idle(4);
        bus_wr(4'hC, 16'h0000);
        idle(2);
    endtask

    logic [15:0] v;

    initial begin
        idle(4);
        @(negedge clk); rst_n = 1'b1;
        cmp_en = 1;

        // R1: reset values
        chk("R1 irq after reset", {12'h0, irq}, 16'h0000);
        bus_rd(4'h4, v); chk("R1 mask reset", v, 16'hFFFF);
        bus_rd(4'hC, v); chk("R1 flag reset", v, 16'h0000);

        // R7: mask load
        bus_wr(4'h4, 16'h0000);
        bus_rd(4'h4, v); chk("R7 mask readback", v, 16'h0000);

        // R2: latency through synchroniser, flag and output register
        @(negedge clk); line_n[3] = 1'b0;
        idle(3); chk("R2 irq0 not yet at E+3", {15'h0, irq[0]}, 16'h0000);
        idle(1); chk("R8 irq0 at E+4", {15'h0, irq[0]}, 16'h0001);
        clear_all();
        chk("R5 irq cleared after flag clear", {12'h0, irq}, 16'h0000);

        // R3: level flag is sticky after line release
        @(negedge clk); line_n[14] = 1'b0;
        idle(3);
        @(negedge clk); line_n[14] = 1'b1;
        idle(4);
        bus_rd(4'hC, v); chk("R3 level flag sticky", v, 16'h4000);
        chk("R8 output 3 group", {12'h0, irq}, 16'h0008);
        clear_all();

        // R5: zeros clear, ones keep
        @(negedge clk); line_n[4] = 1'b0; line_n[10] = 1'b0;
        idle(3);
        @(negedge clk); line_n = 16'hFFFF;
        idle(4);
        chk("R8 outputs 1 and 2", {12'h0, irq}, 16'h0006);
        bus_wr(4'hC, 16'hFBFF);
        bus_rd(4'hC, v); chk("R5 selective clear", v, 16'h0010);
        clear_all();

        // R6: set beats clear while line stays low
        @(negedge clk); line_n[5] = 1'b0;
        idle(4);
        bus_wr(4'hC, 16'h0000);
        bus_rd(4'hC, v); chk("R6 set wins over clear", v, 16'h0020);
        clear_all();

        // R4 and R9: edge input and inputs outside all groups
        @(negedge clk); line_n[15] = 1'b0; line_n[0] = 1'b0;
        idle(5);
        bus_rd(4'hC, v); chk("R4 edge flag set", v, 16'h8001);
        chk("R9 no output for ungrouped flags", {12'h0, irq}, 16'h0000);
        bus_wr(4'hC, 16'h0000);
        idle(3);
        bus_rd(4'hC, v); chk("R4 held-low edge line stays clear", v, 16'h0001);
        clear_all();

        // R7: mask blocks output but not capture
        bus_wr(4'h4, 16'h1000);
        @(negedge clk); line_n[12] = 1'b0;
        idle(3);
        @(negedge clk); line_n[12] = 1'b1;
        idle(3);
        chk("R7 masked group output low", {12'h0, irq}, 16'h0000);
        bus_rd(4'hC, v); chk("R7 masked flag still captured", v, 16'h1000);
        bus_wr(4'h4, 16'h0000);
        idle(1);
        chk("R7 unmasked output high", {12'h0, irq}, 16'h0004);

        // R10: unmapped address reads zero, write ignored
        bus_wr(4'h8, 16'h0000);
        bus_rd(4'h8, v); chk("R10 unmapped reads zero", v, 16'h0000);
        bus_rd(4'hC, v); chk("R10 unmapped write ignored (flags)", v, 16'h1000);
        bus_rd(4'h4, v); chk("R10 unmapped write ignored (mask)", v, 16'h0000);
        clear_all();

        // random phase, checked against the model every cycle
        for (int n = 0; n < 3000; n++) begin
            @(negedge clk);
            if (($urandom % 4) == 0) line_n = 16'($urandom);
            bwe = (($urandom % 5) == 0);
            case ($urandom % 4)
                0: baddr = 4'h4;
                1: baddr = 4'hC;
                2: baddr = 4'h8;
                default: baddr = 4'h0;
            endcase
            bwd = 16'($urandom);
        end
        @(negedge clk); bwe = 1'b0;
        idle(2);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule